// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the line and field timing for a display output. From programmed active, front-porch, sync and back-porch lengths it drives horizontal sync, vertical sync and a data-enable window, and it emits a one-cycle field-start pulse that tells an upstream compositor to begin a new field. It supports progressive and interlaced scan. In interlaced mode, odd and even fields each use their own vertical register set, and each field can shift its vertical-sync edges by a programmed number of clocks along the line, so the odd field can sit half a line away from the even one.

Horizontal lengths are given in output clocks. For double-clocked output, software writes them already multiplied by two and sets the repeat field. The block then issues a pixel request only on every second active clock. A sticky status bit with a mask raises an interrupt when a field enters its vertical front porch, and the status bit is cleared by writing one to it. A clear pulse for the downstream pixel FIFO can come from a command bit or automatically at every field start.

A single register write port sets everything up. The generator starts when the video-enable bit is written and stops cleanly at the next field boundary.

Top module: `scan_timing_gen`

## Requirements
- R1: The line order is active, front porch, sync, back porch. Horizontal lengths are fields of word 2 (active [15:0], front porch [31:16]) and word 3 (sync [15:0], back porch [31:16]). Data-enable is high only in the active span of active lines, and hsync is high only in the sync span.
- R2: The field order is active lines, front porch lines, sync lines, back porch lines. The primary set is word 4 (active [15:0], front porch [31:16]) and word 5 (sync [15:0], back porch [31:16]). Progressive scan always uses the primary set and holds the parity output low.
- R3: Interlace is VCTRL (word 1) bit 2. Fields then alternate, starting with an odd field. The odd field uses the primary set and drives parity high. The even field uses the secondary set in words 6 and 7 (same layout) and drives parity low.
- R4: Both vsync edges are moved later in the line by a delay, counted in clocks from the line start. The odd field uses VCTRL[31:16], the even field uses word 8 [15:0], and progressive scan uses zero.
- R5: Counters sit at the first position and all timing outputs stay low while the generator is stopped. Writing one to VCTRL bit 0 (video enable) starts the generator from the first position. The field-start output pulses for one cycle at the first clock of every field.
- R6: After video enable is cleared, the current field still completes. The videoOn output stays high until the generator has stopped. With VCTRL bit 1 (continuous) low, the generator runs a single field and then clears video enable by itself.
- R7: A status bit is set at the first clock of the first front-porch line. The interrupt output is status AND mask, with the mask at word 9 bit 0. Writing one to word 10 bit 0 clears the status.
- R8: Writing one to word 0 bit 0 makes fifoClr pulse high for exactly one cycle after the write. With word 0 bit 1 set, fifoClr is also high on every field-start cycle.
- R9: Word 0 bit 2 holds the repeat factor minus one. At factor 1 the pixel-request output follows data-enable. At factor 2 it is high only on the even-numbered clocks of the active span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Register write data |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data-enable window |
| pixStrobe | output | 1 | Pixel request, thinned when repeat is on |
| fieldOdd | output | 1 | Field parity, high in odd interlaced fields |
| frameStart | output | 1 | One-cycle pulse at each field start |
| vfpIrq | output | 1 | Masked front-porch interrupt |
| fifoClr | output | 1 | Clear pulse to downstream pixel FIFO |
| videoOn | output | 1 | Enable readback, high until stopped |

## Verification
The bench compares every output cycle by cycle over back-to-back fields and goes after these corner cases:

- **Half-line vsync shift and the one-line-shorter even field in interlaced mode.** A design that used the wrong register set would give the wrong field length. A design that ignored the delay would move its vsync edges to the line start.
- **Stop at a field boundary.** Video enable is cleared in the middle of a field. A generator that stopped at once would truncate the field. One that never stopped would raise a further field-start pulse.
- **Single-field mode.** A generator that failed to drop its enable would go on running.
- **Interrupt masking and write-one-to-clear, pixel thinning in repeat mode, and the one-cycle FIFO clear command.** Each is checked at the outputs in the cycle it is due.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  localparam int LEN_W = 12;
  localparam int POS_W = LEN_W + 2;

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [POS_W-1:0] pos_t;

  // one axis of timing: lengths in clocks (horizontal) or lines (vertical)
  typedef struct packed {
    len_t act;
    len_t fp;
    len_t sync;
    len_t bp;
  } span_t;

  typedef struct packed {
    span_t hor;
    span_t verA;
    span_t verB;
    len_t  oddDly;
    len_t  evenDly;
    logic  interlace;
    logic  rep2;
  } cfg_t;

  typedef struct packed {
    logic run;
  } ctrl_strb_t;

  typedef struct packed {
    logic fieldStart;
    logic fieldEnd;
    logic vfpStart;
  } dp_evt_t;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_VCTRL = 1;
  localparam int ADR_HLO   = 2;
  localparam int ADR_HHI   = 3;
  localparam int ADR_ALO   = 4;
  localparam int ADR_AHI   = 5;
  localparam int ADR_BLO   = 6;
  localparam int ADR_BHI   = 7;
  localparam int ADR_EDLY  = 8;
  localparam int ADR_INTEN = 9;
  localparam int ADR_STAT  = 10;

  function automatic pos_t spanTotal(span_t s);
    return pos_t'(s.act) + pos_t'(s.fp) + pos_t'(s.sync) + pos_t'(s.bp);
  endfunction
endpackage

// File: rtl/scan_timing_ctrl.sv
module scan_timing_ctrl
  import scan_timing_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  dp_evt_t           evt,
  output ctrl_strb_t        strb,
  output cfg_t              cfg,
  output logic              videoOn,
  output logic              irqOut,
  output logic              fifoClr
);
  localparam int HI_LSB = DATA_W / 2;

  cfg_t cfgQ;
  logic vEn, contQ, clrAtStart, intEn, irqStat, clrCmdQ, running;
  len_t loF, hiF;
  logic wCtrl, wVctrl, wStat;
  logic unusedData;

  assign loF    = regWrData[LEN_W-1:0];
  assign hiF    = regWrData[HI_LSB +: LEN_W];
  assign wCtrl  = regWrEn && regAddr == ADDR_W'(ADR_CTRL);
  assign wVctrl = regWrEn && regAddr == ADDR_W'(ADR_VCTRL);
  assign wStat  = regWrEn && regAddr == ADDR_W'(ADR_STAT);
  assign unusedData = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ       <= '0;
      vEn        <= 1'b0;
      contQ      <= 1'b0;
      clrAtStart <= 1'b0;
      intEn      <= 1'b0;
      irqStat    <= 1'b0;
      clrCmdQ    <= 1'b0;
      running    <= 1'b0;
    end else begin
      clrCmdQ <= wCtrl && regWrData[0];
      if (regWrEn) begin
        case (regAddr)
          ADDR_W'(ADR_CTRL): begin
            clrAtStart <= regWrData[1];
            cfgQ.rep2  <= regWrData[2];
          end
          ADDR_W'(ADR_VCTRL): begin
            contQ          <= regWrData[1];
            cfgQ.interlace <= regWrData[2];
            cfgQ.oddDly    <= hiF;
          end
          ADDR_W'(ADR_HLO):   begin cfgQ.hor.act  <= loF; cfgQ.hor.fp  <= hiF; end
          ADDR_W'(ADR_HHI):   begin cfgQ.hor.sync <= loF; cfgQ.hor.bp  <= hiF; end
          ADDR_W'(ADR_ALO):   begin cfgQ.verA.act <= loF; cfgQ.verA.fp <= hiF; end
          ADDR_W'(ADR_AHI):   begin cfgQ.verA.sync <= loF; cfgQ.verA.bp <= hiF; end
          ADDR_W'(ADR_BLO):   begin cfgQ.verB.act <= loF; cfgQ.verB.fp <= hiF; end
          ADDR_W'(ADR_BHI):   begin cfgQ.verB.sync <= loF; cfgQ.verB.bp <= hiF; end
          ADDR_W'(ADR_EDLY):  cfgQ.evenDly <= loF;
          ADDR_W'(ADR_INTEN): intEn <= regWrData[0];
          default: ;
        endcase
      end
      // enable bit: software write wins, single-field mode self-clears
      if (wVctrl) vEn <= regWrData[0];
      else if (running && evt.fieldEnd && !contQ) vEn <= 1'b0;
      // run state changes only at field boundaries once started
      if (!running) running <= vEn;
      else if (evt.fieldEnd && (!vEn || !contQ)) running <= 1'b0;
      // status: a new event beats a same-cycle clear
      if (evt.vfpStart) irqStat <= 1'b1;
      else if (wStat && regWrData[0]) irqStat <= 1'b0;
    end
  end

  assign cfg      = cfgQ;
  assign strb.run = running;
  assign videoOn  = vEn | running;
  assign irqOut   = irqStat & intEn;
  assign fifoClr  = clrCmdQ | (clrAtStart & evt.fieldStart);

  // R5
  start_at_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> evt.fieldStart);
  // R6
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(evt.fieldEnd));
  // R7
  vfp_status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.vfpStart |=> irqStat);
  // R8
  clr_cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wCtrl && regWrData[0]) |=> fifoClr);
endmodule

// File: rtl/scan_timing_dp.sv
module scan_timing_dp
  import scan_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_strb_t strb,
  input  cfg_t       cfg,
  output dp_evt_t    evt,
  output logic       deOut,
  output logic       hsOut,
  output logic       vsOut,
  output logic       fieldOdd,
  output logic       pixStrobe
);
  pos_t  hPos, vPos;
  logic  oddQ;
  span_t vs;
  pos_t  hTot, vTot, hsStart, hsStop, vsStart, vsStop, dly;
  logic  lineEnd, lastLine, afterStart, beforeStop;

  assign vs      = (cfg.interlace && !oddQ) ? cfg.verB : cfg.verA;
  assign hTot    = spanTotal(cfg.hor);
  assign vTot    = spanTotal(vs);
  assign hsStart = pos_t'(cfg.hor.act) + pos_t'(cfg.hor.fp);
  assign hsStop  = hsStart + pos_t'(cfg.hor.sync);
  assign vsStart = pos_t'(vs.act) + pos_t'(vs.fp);
  assign vsStop  = vsStart + pos_t'(vs.sync);
  assign dly     = !cfg.interlace ? '0 : oddQ ? pos_t'(cfg.oddDly) : pos_t'(cfg.evenDly);
  assign lineEnd  = hPos == hTot - pos_t'(1);
  assign lastLine = vPos == vTot - pos_t'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= '0;
      vPos <= '0;
      oddQ <= 1'b1;
    end else if (!strb.run) begin
      hPos <= '0;
      vPos <= '0;
      oddQ <= 1'b1;
    end else if (lineEnd) begin
      hPos <= '0;
      if (lastLine) begin
        vPos <= '0;
        if (cfg.interlace) oddQ <= ~oddQ;
      end else begin
        vPos <= vPos + pos_t'(1);
      end
    end else begin
      hPos <= hPos + pos_t'(1);
    end
  end

  // vsync window in (line, clock) order, both edges shifted by dly
  assign afterStart = (vPos > vsStart) || (vPos == vsStart && hPos >= dly);
  assign beforeStop = (vPos < vsStop)  || (vPos == vsStop  && hPos <  dly);

  assign deOut     = strb.run && hPos < pos_t'(cfg.hor.act) && vPos < pos_t'(vs.act);
  assign hsOut     = strb.run && hPos >= hsStart && hPos < hsStop;
  assign vsOut     = strb.run && afterStart && beforeStop;
  assign fieldOdd  = strb.run && cfg.interlace && oddQ;
  assign pixStrobe = deOut && (!cfg.rep2 || !hPos[0]);

  assign evt.fieldStart = strb.run && hPos == '0 && vPos == '0;
  assign evt.fieldEnd   = strb.run && lineEnd && lastLine;
  assign evt.vfpStart   = strb.run && hPos == '0 && vPos == pos_t'(vs.act);

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (hPos == '0 && vPos == '0 && oddQ));
  // R1
  de_hsync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> !hsOut);
  // R1
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && hTot != '0) |-> hPos < hTot);
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pixStrobe,
  output logic              fieldOdd,
  output logic              frameStart,
  output logic              vfpIrq,
  output logic              fifoClr,
  output logic              videoOn
);
  ctrl_strb_t strb;
  cfg_t       cfg;
  dp_evt_t    evt;

  scan_timing_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .evt(evt), .strb(strb), .cfg(cfg),
    .videoOn(videoOn), .irqOut(vfpIrq), .fifoClr(fifoClr)
  );

  scan_timing_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .evt(evt),
    .deOut(deOut), .hsOut(hsyncOut), .vsOut(vsyncOut),
    .fieldOdd(fieldOdd), .pixStrobe(pixStrobe)
  );

  assign frameStart = evt.fieldStart;
endmodule

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;
  localparam int PER = 10;
  localparam int HACT = 8, HFP = 2, HSY = 3, HBP = 3;
  localparam int HTOT = HACT + HFP + HSY + HBP;
  localparam int VACT = 4, VFP = 2, VSY = 2, VBPA = 3, VBPB = 2;
  localparam int FLEN_A = HTOT * (VACT + VFP + VSY + VBPA);
  localparam int IDLE = 6;

  typedef struct {
    logic [6:0] bits; // de hs vs fo fs ps fc
    string      tag;
  } exp_t;

  logic        clk = 0, rstN = 0, wrEn = 0;
  logic [3:0]  addr = '0;
  logic [31:0] data = '0;
  logic hs, vs, de, ps, fo, fs, irq, fc, von;
  int   nCmp = 0, nBad = 0;
  bit   finished = 0;
  exp_t q[$];

  scan_timing_gen i_scan_timing_gen (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regAddr(addr), .regWrData(data),
    .hsyncOut(hs), .vsyncOut(vs), .deOut(de), .pixStrobe(ps), .fieldOdd(fo),
    .frameStart(fs), .vfpIrq(irq), .fifoClr(fc), .videoOn(von)
  );

  always #(PER/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; data = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  // expected outputs of one whole field, derived from the requirements
  task automatic pushField(input bit useB, input bit odd, input int dly,
                           input bit ilace, input bit rep, input bit clrStart,
                           input string tag);
    int vbp, vtot, vsS, vsE;
    vbp  = useB ? VBPB : VBPA;
    vtot = VACT + VFP + VSY + vbp;
    vsS  = (VACT + VFP) * HTOT + dly;
    vsE  = (VACT + VFP + VSY) * HTOT + dly;
    for (int v = 0; v < vtot; v++) begin
      for (int h = 0; h < HTOT; h++) begin
        exp_t e;
        int idx;
        logic eDe, eHs, eVs, eFs;
        idx = v * HTOT + h;
        eDe = (v < VACT) && (h < HACT);
        eHs = (h >= HACT + HFP) && (h < HACT + HFP + HSY);
        eVs = (idx >= vsS) && (idx < vsE);
        eFs = (idx == 0);
        e.bits = {eDe, eHs, eVs, ilace & odd, eFs,
                  eDe & (!rep || (h % 2 == 0)), clrStart & eFs};
        e.tag = tag;
        q.push_back(e);
      end
    end
  endtask

  task automatic pushIdle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.bits = '0;
      e.tag  = "R6 idle after stop";
      q.push_back(e);
    end
  endtask

  task automatic drainTo(input int n);
    while (q.size() > n) @(negedge clk);
  endtask

  // monitor: one comparison per cycle while expectations are queued
  initial begin
    forever begin
      @(posedge clk);
      #(PER/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, {25'd0, de, hs, vs, fo, fs, ps, fc}, {25'd0, e.bits});
      end
    end
  end

  initial begin
    #(PER * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R5 reset state: all outputs inactive
    chk("R5 reset outputs", {23'd0, hs, vs, de, ps, fo, fs, irq, fc, von}, 32'd0);

    regWrite(4'd2, (HFP << 16) | HACT);
    regWrite(4'd3, (HBP << 16) | HSY);
    regWrite(4'd4, (VFP << 16) | VACT);
    regWrite(4'd5, (VBPA << 16) | VSY);
    regWrite(4'd6, (VFP << 16) | VACT);
    regWrite(4'd7, (VBPB << 16) | VSY);
    regWrite(4'd8, 32'd2);
    regWrite(4'd9, 32'd1);
    chk("R5 still idle after setup", {31'd0, von}, 32'd0);

    // progressive, continuous: R1 R2 R5 timing, R6 stop at field end
    regWrite(4'd1, 32'h3);
    pushField(0, 1, 0, 0, 0, 0, "R1/R2 progressive field 1");
    pushField(0, 1, 0, 0, 0, 0, "R2/R5 progressive field 2");
    pushField(0, 1, 0, 0, 0, 0, "R6 field finishing after disable");
    pushIdle(IDLE);
    drainTo(IDLE + FLEN_A - 10);
    regWrite(4'd1, 32'h2);
    chk("R6 videoOn held while field completes", {31'd0, von}, 32'd1);
    drainTo(0);
    @(negedge clk);
    chk("R6 videoOn low after stop", {31'd0, von}, 32'd0);
    chk("R7 interrupt raised by front porch", {31'd0, irq}, 32'd1);
    regWrite(4'd9, 32'd0);
    chk("R7 mask hides status", {31'd0, irq}, 32'd0);
    regWrite(4'd9, 32'd1);
    chk("R7 status still pending", {31'd0, irq}, 32'd1);
    regWrite(4'd10, 32'd1);
    chk("R7 write-one clears status", {31'd0, irq}, 32'd0);

    // single-field mode
    regWrite(4'd1, 32'h1);
    pushField(0, 1, 0, 0, 0, 0, "R6 single field");
    pushIdle(IDLE);
    drainTo(0);
    @(negedge clk);
    chk("R6 single field clears enable", {31'd0, von}, 32'd0);

    // interlaced, repeat 2, clear at field start: R3 R4 R8 R9
    regWrite(4'd0, 32'h6);
    regWrite(4'd1, 32'h0008_0007);
    pushField(0, 1, 8, 1, 1, 1, "R3/R4/R9 odd field");
    pushField(1, 0, 2, 1, 1, 1, "R3/R4/R8 even field");
    pushField(0, 1, 8, 1, 1, 1, "R3/R4 second odd field");
    pushIdle(IDLE);
    drainTo(IDLE + FLEN_A - 10);
    regWrite(4'd1, 32'h0008_0006);
    drainTo(0);
    @(negedge clk);
    chk("R6 interlaced run stopped", {31'd0, von}, 32'd0);

    // FIFO clear command
    regWrite(4'd0, 32'h1);
    chk("R8 clear command pulse", {31'd0, fc}, 32'd1);
    @(negedge clk);
    chk("R8 clear pulse one cycle", {31'd0, fc}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule